// File: doc/BRIEF.md
# VME-style Strobe-to-Local-Handshake Bridge Controller

This block is a clocked sequencer that sits between a bus slave's data-strobe side and a local device that speaks a four-phase request/acknowledge handshake. The bus master raises a read strobe or a write strobe. The controller then drives three outputs: a data-transceiver enable, a local request to the device and an acknowledge back to the bus. It moves these outputs through a fixed order of steps, and each step waits for its own triggering input.

A read opens the local handshake first and turns the transceiver on only once the device has acknowledged. A write turns the transceiver on first, opens the local handshake, and turns the transceiver off again after the device acknowledges. In both cases the bus acknowledge follows the transceiver step. On the way back, the local request is dropped while the bus side returns to zero. The controller does not wait for the device to withdraw its acknowledge before it returns to idle. That wait is deferred to the next time it raises the local request. Address decoding, the data path and arbitration sit outside the block. All inputs are taken as synchronous to the clock.

Top module: `vmeBridge`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the controller in idle with xcvrEn, locReq, busAck and protoErr all low.
- R2: Read forward path: after rdStrobe rises in idle, locReq rises; once locAck is seen high, xcvrEn rises; on the next edge busAck rises.
- R3: Read return path: after rdStrobe falls with busAck high, xcvrEn falls, then locReq falls, then busAck falls and the controller is idle again.
- R4: Write forward path: after wrStrobe rises in idle, xcvrEn rises, then locReq rises; once locAck is seen high, xcvrEn falls; on the next edge busAck rises.
- R5: Write return path: after wrStrobe falls with busAck high, locReq falls, then busAck falls and the controller is idle again.
- R6: locReq never rises while locAck is high. A new read or write whose local request is due waits, with locReq low, until locAck has fallen.
- R7: At most one of xcvrEn, locReq and busAck changes at any clock edge. Each change is registered and happens at the first edge at which its trigger is sampled.
- R8: If rdStrobe and wrStrobe are both high while idle, no output changes and protoErr is high one edge later, for as long as both stay high. The controller stays idle throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdStrobe | input | 1 | Bus read data strobe, active high |
| wrStrobe | input | 1 | Bus write data strobe, active high |
| locAck | input | 1 | Local device acknowledge, active high |
| xcvrEn | output | 1 | Data-transceiver enable |
| locReq | output | 1 | Local device request strobe |
| busAck | output | 1 | Bus data acknowledge |
| protoErr | output | 1 | Both strobes seen high while idle |

## Verification
The properties assume that the environment keeps to the handshake. The device raises locAck only while locReq is high and lowers it only after locReq has fallen. The bus master releases its strobe only after busAck has risen, and it does not start a new strobe until busAck is low. The bench's device and master models react to the observed outputs at the falling clock edge and respect exactly these rules. The device can hold locAck high after the release, which exercises the deferred wait of the next request. The single exception is a deliberate period in idle with both strobes high. In that period the properties expect silence on the outputs rather than a cycle.

// File: rtl/vmeBridge_pkg.sv
package vmeBridge_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_WAIT_ACK,
    ST_RD_XON,
    ST_RD_HOLD,
    ST_RD_REL,
    ST_WR_WAIT_FREE,
    ST_WR_WAIT_ACK,
    ST_WR_XOFF,
    ST_WR_HOLD,
    ST_FIN
  } ctlState_t;

  // one-edge step commands from control to the output registers
  typedef struct packed {
    logic xcvrSet;
    logic xcvrClr;
    logic reqSet;
    logic reqClr;
    logic ackSet;
    logic ackClr;
    logic errFlag;
  } stepCmd_t;

endpackage

// File: rtl/vmeBridge_ctl.sv
module vmeBridge_ctl
  import vmeBridge_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rdStrobe,
  input  logic     wrStrobe,
  input  logic     locAck,
  output stepCmd_t cmd
);

  ctlState_t curState, nxtState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    cmd      = '0;
    case (curState)
      ST_IDLE: begin
        if (rdStrobe && wrStrobe) begin
          cmd.errFlag = 1'b1;
        end else if (rdStrobe) begin
          // local request may only open once the previous ack is gone
          if (!locAck) begin
            cmd.reqSet = 1'b1;
            nxtState   = ST_RD_WAIT_ACK;
          end
        end else if (wrStrobe) begin
          cmd.xcvrSet = 1'b1;
          nxtState    = ST_WR_WAIT_FREE;
        end
      end
      ST_RD_WAIT_ACK: begin
        if (locAck) begin
          cmd.xcvrSet = 1'b1;
          nxtState    = ST_RD_XON;
        end
      end
      ST_RD_XON: begin
        cmd.ackSet = 1'b1;
        nxtState   = ST_RD_HOLD;
      end
      ST_RD_HOLD: begin
        if (!rdStrobe) begin
          cmd.xcvrClr = 1'b1;
          nxtState    = ST_RD_REL;
        end
      end
      ST_RD_REL: begin
        cmd.reqClr = 1'b1;
        nxtState   = ST_FIN;
      end
      ST_WR_WAIT_FREE: begin
        if (!locAck) begin
          cmd.reqSet = 1'b1;
          nxtState   = ST_WR_WAIT_ACK;
        end
      end
      ST_WR_WAIT_ACK: begin
        if (locAck) begin
          cmd.xcvrClr = 1'b1;
          nxtState    = ST_WR_XOFF;
        end
      end
      ST_WR_XOFF: begin
        cmd.ackSet = 1'b1;
        nxtState   = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        if (!wrStrobe) begin
          cmd.reqClr = 1'b1;
          nxtState   = ST_FIN;
        end
      end
      ST_FIN: begin
        // bus side returns to idle without waiting for the device release
        cmd.ackClr = 1'b1;
        nxtState   = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/vmeBridge_outRegs.sv
module vmeBridge_outRegs
  import vmeBridge_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  stepCmd_t cmd,
  output logic     xcvrEn,
  output logic     locReq,
  output logic     busAck,
  output logic     protoErr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      xcvrEn   <= 1'b0;
      locReq   <= 1'b0;
      busAck   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (cmd.xcvrSet)      xcvrEn <= 1'b1;
      else if (cmd.xcvrClr) xcvrEn <= 1'b0;
      if (cmd.reqSet)       locReq <= 1'b1;
      else if (cmd.reqClr)  locReq <= 1'b0;
      if (cmd.ackSet)       busAck <= 1'b1;
      else if (cmd.ackClr)  busAck <= 1'b0;
      protoErr <= cmd.errFlag;
    end
  end

endmodule

// File: rtl/vmeBridge.sv
module vmeBridge
  import vmeBridge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rdStrobe,
  input  logic wrStrobe,
  input  logic locAck,
  output logic xcvrEn,
  output logic locReq,
  output logic busAck,
  output logic protoErr
);

  stepCmd_t stepCmd;

  vmeBridge_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .locAck   (locAck),
    .cmd      (stepCmd)
  );

  vmeBridge_outRegs u_regs (
    .clk      (clk),
    .rst      (rst),
    .cmd      (stepCmd),
    .xcvrEn   (xcvrEn),
    .locReq   (locReq),
    .busAck   (busAck),
    .protoErr (protoErr)
  );

endmodule

// File: rtl/vmeBridge_chk.sv
module vmeBridge_chk (
  input logic clk,
  input logic rst,
  input logic rdStrobe,
  input logic wrStrobe,
  input logic locAck,
  input logic xcvrEn,
  input logic locReq,
  input logic busAck,
  input logic protoErr
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!xcvrEn && !locReq && !busAck && !protoErr)); // R1

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones({xcvrEn, locReq, busAck} ^ $past({xcvrEn, locReq, busAck})) <= 1); // R7

  AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(locReq) |-> !$past(locAck)); // R6

  AST_RD_XCVR_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(xcvrEn) && $past(locReq)) |-> $past(locAck)); // R2

  AST_BUS_ACK_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busAck) |-> ($past(locReq) && $past(locAck))); // R4

  AST_WR_XCVR_OFF: assert property (@(posedge clk) disable iff (rst)
    ($fell(xcvrEn) && $past(wrStrobe) && !$past(rdStrobe)) |-> $past(locAck)); // R4

  AST_RETURN_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(busAck) |-> (!locReq && !xcvrEn)); // R3

  AST_WR_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(locReq) && !$past(xcvrEn) && $past(wrStrobe)) |-> 1'b0); // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    protoErr |-> (!xcvrEn && !locReq && !busAck)); // R8

endmodule

bind vmeBridge vmeBridge_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rdStrobe (rdStrobe),
  .wrStrobe (wrStrobe),
  .locAck   (locAck),
  .xcvrEn   (xcvrEn),
  .locReq   (locReq),
  .busAck   (busAck),
  .protoErr (protoErr)
);

// File: tb/vmeBridge_bench.sv
module vmeBridge_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdStrobe = 1'b0;
  logic wrStrobe = 1'b0;
  logic locAck = 1'b0;
  logic xcvrEn, locReq, busAck, protoErr;

  always #10 clk = ~clk;

  vmeBridge u_vmeBridge (
    .clk(clk), .rst(rst), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .locAck(locAck), .xcvrEn(xcvrEn), .locReq(locReq), .busAck(busAck),
    .protoErr(protoErr)
  );

  // change codes: index*2 + new value; index 0 xcvrEn, 1 locReq, 2 busAck
  localparam int X_DN = 0, X_UP = 1, L_DN = 2, L_UP = 3, A_DN = 4, A_UP = 5;

  typedef struct { int code; string req; } expItem_t;
  expItem_t expQ[$];

  int nChecks = 0;
  int nFail = 0;
  logic [2:0] prevOut = 3'b000;
  logic [2:0] curOut;
  assign curOut = {busAck, locReq, xcvrEn};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic pushExp(input int code, input string req);
    expItem_t it;
    it.code = code;
    it.req  = req;
    expQ.push_back(it);
  endtask

  // monitor: compares every observed output change with the queue head
  always @(negedge clk) begin
    if (rst) begin
      prevOut = curOut;
    end else begin
      logic [2:0] diff;
      diff = curOut ^ prevOut;
      if ($countones(diff) > 1)
        check(1'b0, "R7", "outputs changed together", int'(diff), 0);
      for (int i = 0; i < 3; i++) begin
        if (diff[i]) begin
          int got;
          got = i * 2 + int'(curOut[i]);
          if (expQ.size() == 0) begin
            check(1'b0, "R7", "unexpected output change", got, -1);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(got == e.code, e.req, "output step order", got, e.code);
          end
        end
      end
      prevOut = curOut;
    end
  end

  task automatic waitOut(input int idx, input logic val, input string req);
    int n = 0;
    while (curOut[idx] !== val && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (curOut[idx] !== val)
      check(1'b0, req, "timeout waiting for output", int'(curOut[idx]), int'(val));
  endtask

  // holdPrev: locAck is still high from the previous cycle on entry
  // slowRel: leave locAck high after locReq falls
  task automatic readCycle(input bit holdPrev, input bit slowRel);
    pushExp(L_UP, "R2"); pushExp(X_UP, "R2"); pushExp(A_UP, "R2");
    pushExp(X_DN, "R3"); pushExp(L_DN, "R3"); pushExp(A_DN, "R3");
    @(negedge clk) rdStrobe = 1'b1;
    if (holdPrev) begin
      repeat (5) @(negedge clk);
      check(locReq == 1'b0, "R6", "read request held off by locAck", int'(locReq), 0);
      locAck = 1'b0;
    end
    waitOut(1, 1'b1, "R2");
    @(negedge clk) locAck = 1'b1;
    waitOut(2, 1'b1, "R2");
    @(negedge clk) rdStrobe = 1'b0;
    waitOut(1, 1'b0, "R3");
    if (!slowRel) locAck = 1'b0;
    waitOut(2, 1'b0, "R3");
    @(negedge clk);
  endtask

  task automatic writeCycle(input bit holdPrev, input bit slowRel);
    pushExp(X_UP, "R4"); pushExp(L_UP, "R4"); pushExp(X_DN, "R4");
    pushExp(A_UP, "R4"); pushExp(L_DN, "R5"); pushExp(A_DN, "R5");
    @(negedge clk) wrStrobe = 1'b1;
    waitOut(0, 1'b1, "R4");
    if (holdPrev) begin
      repeat (5) @(negedge clk);
      check(locReq == 1'b0, "R6", "write request held off by locAck", int'(locReq), 0);
      check(xcvrEn == 1'b1, "R4", "transceiver on while request waits", int'(xcvrEn), 1);
      locAck = 1'b0;
    end
    waitOut(1, 1'b1, "R4");
    @(negedge clk) locAck = 1'b1;
    waitOut(2, 1'b1, "R4");
    @(negedge clk) wrStrobe = 1'b0;
    waitOut(1, 1'b0, "R5");
    if (!slowRel) locAck = 1'b0;
    waitOut(2, 1'b0, "R5");
    @(negedge clk);
  endtask

  task automatic finishRun;
    check(expQ.size() == 0, "R7", "expected steps left unseen", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(curOut == 3'b000 && protoErr == 1'b0, "R1", "outputs in reset",
          int'({protoErr, curOut}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    readCycle(1'b0, 1'b0);
    writeCycle(1'b0, 1'b0);
    readCycle(1'b0, 1'b1);   // device release slow
    readCycle(1'b1, 1'b1);   // R6: new read waits, previous release slow again
    writeCycle(1'b1, 1'b1);  // R6: write waits for release
    writeCycle(1'b1, 1'b0);
    check(protoErr == 1'b0, "R8", "no error flag in legal cycles", int'(protoErr), 0);

    // R8: both strobes together in idle
    @(negedge clk) begin rdStrobe = 1'b1; wrStrobe = 1'b1; end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(protoErr == 1'b1, "R8", "error flag with both strobes", int'(protoErr), 1);
      check(curOut == 3'b000, "R8", "outputs quiet with both strobes", int'(curOut), 0);
    end
    rdStrobe = 1'b0; wrStrobe = 1'b0;
    @(negedge clk);
    check(protoErr == 1'b0, "R8", "error flag clears", int'(protoErr), 0);
    readCycle(1'b0, 1'b0);   // still idle-capable afterwards

    // R1: reset in the middle of a write
    pushExp(X_UP, "R4"); pushExp(L_UP, "R4");
    @(negedge clk) wrStrobe = 1'b1;
    waitOut(1, 1'b1, "R4");
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check(curOut == 3'b000 && protoErr == 1'b0, "R1", "outputs after mid-cycle reset",
          int'({protoErr, curOut}), 0);
    expQ.delete();
    wrStrobe = 1'b0; locAck = 1'b0;
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    check(curOut == 3'b000, "R1", "idle holds after reset", int'(curOut), 0);
    writeCycle(1'b0, 1'b0);

    finishRun();
  end

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule